// File: doc/BRIEF.md
# Streaming 2D Field-Update Stencil Stage

This block performs one time step of a two-dimensional electromagnetic finite-difference update on a rectangular grid. The grid is streamed through it one cell per clock in row-major order, with the column index running fastest. Each input cell carries the two electric field components (horizontal `ex`, vertical `ey`), the magnetic component `hz`, an accumulated magnetic energy value and a one-bit material flag. The block returns the updated four values for every cell on a valid/ready output stream. All values are signed fixed point with saturation, so no floating-point unit is required.

The electric update of row r is done as row r enters. The magnetic update of the same column one row earlier is done in the same clock, because it depends on electric values at positive offsets. Per-column line buffers hold the previous row's old `hz`, old energy, material flag and freshly computed `ex`/`ey`. Each buffer is read at most once per clock. A single-entry register supplies the horizontally adjacent `ex` value. Results therefore leave one row behind the input. A flush row of `grid_w_i` clocks, which takes no input, drains the last row. An additive source term is injected into `hz` at one selectable cell. The per-cell coefficient set is chosen by the material flag.

Top module: `fdtd_stream_stage`

## Requirements
- R1: After reset `out_valid_o` is 0 and, with `grid_h_i` ≥ 1, `in_ready_o` is 1.
- R2: For input cell (r,c), with Q-format multiply `mul(a,b)=sat((a*b)>>>FRAC_W)`, saturating `add`/`sub`, and old values `hz`, `hz_l` (old hz at (r,c-1), 0 when c=0) and `hz_u` (old hz at (r-1,c), 0 when r=0): `ex' = add(mul(ca,ex), mul(cb, sub(hz, hz_l)))` and `ey' = add(mul(ca,ey), mul(cb, sub(hz_u, hz)))`.
- R3: For cell (r,c), `hz' = add(mul(da,hz), mul(db, add(sub(exR, ex'), sub(ey', eyD))))`. Here `exR` is ex' at (r,c+1) (0 in the last column), `eyD` is ey' at (r+1,c) (0 in the last row), and `hz`, `ex'`, `ey'` belong to (r,c).
- R4: The material flag selects the coefficients. Flag 0 uses bits [DATA_W-1:0] and flag 1 uses bits [2*DATA_W-1:DATA_W] of each of `ca_i`, `cb_i`, `da_i`, `db_i`. The H update uses the flag of the cell being updated.
- R5: At the cell where row equals `src_row_i` and column equals `src_col_i`, `src_val_i` is added with saturation to hz' from R3.
- R6: The energy output is `add(en, mul(hz_out, hz_out))`, where `en` is the cell's input energy and `hz_out` the final field of R3/R5.
- R7: Every add, subtract and multiply result clamps to the most positive value (0x7FFFFFFF for 32 bits) or the most negative value (0x80000000) instead of wrapping.
- R8: Results leave in row-major order, exactly `grid_w_i*grid_h_i` per pass. Row 0 input produces no output. A flush row of `grid_w_i` steps takes no input (`in_ready_o` low) and emits the last row. Any step that consumes a cell of row ≥ 1 has its result valid on the next clock.
- R9: While `out_valid_o` is high and `out_ready_i` is low, the output stays valid and all output data stay unchanged.
- R10: With `in_valid_i` and `out_ready_i` held high, one cell is taken per clock. The last result of a pass is accepted `grid_w_i*(grid_h_i+1)` clocks after the first cell is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| grid_w_i | input | COL_W+1 | Grid width in cells (≥ 2, ≤ MAX_W) |
| grid_h_i | input | ROW_W | Grid height in rows (≥ 1, ≤ MAX_H) |
| src_row_i | input | ROW_W | Source cell row |
| src_col_i | input | COL_W | Source cell column |
| src_val_i | input | DATA_W | Source value added to hz |
| ca_i | input | 2*DATA_W | E self coefficient, {metal, vacuum} |
| cb_i | input | 2*DATA_W | E difference coefficient, {metal, vacuum} |
| da_i | input | 2*DATA_W | H self coefficient, {metal, vacuum} |
| db_i | input | 2*DATA_W | H curl coefficient, {metal, vacuum} |
| in_valid_i | input | 1 | Input cell valid |
| in_ready_o | output | 1 | Input cell accepted when high with valid |
| in_ex_i | input | DATA_W | Old ex |
| in_ey_i | input | DATA_W | Old ey |
| in_hz_i | input | DATA_W | Old hz |
| in_en_i | input | DATA_W | Old accumulated energy |
| in_mat_i | input | 1 | Material flag (0 vacuum, 1 metal) |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Result accepted when high with valid |
| out_ex_o | output | DATA_W | Updated ex |
| out_ey_o | output | DATA_W | Updated ey |
| out_hz_o | output | DATA_W | Updated hz |
| out_en_o | output | DATA_W | Updated energy |

## Verification
A cell of row r ≥ 1 yields the result for (r-1, same column) on the clock after its acceptance. The last row's results follow the flush steps one clock later each. The bench therefore never predicts a cycle for a value. It matches the k-th accepted output against the k-th cell of a row-major reference built from the update equations, and it samples handshakes just before the rising edge. Timing is pinned only in the full-rate pass, where the gap from first input to last output must be exactly width·(height+1) clocks. It is also pinned in the clock after any stalled output, which must repeat the same data.

// File: rtl/fdtd_pkg.sv
package fdtd_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned FRAC_W = 24;

  typedef logic signed [DATA_W-1:0]   fx_t;
  typedef logic signed [2*DATA_W-1:0] wide_t;

  localparam wide_t WIDE_MAX = {{(DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam wide_t WIDE_MIN = {{(DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
  localparam fx_t   FX_MAX   = {1'b0, {(DATA_W-1){1'b1}}};
  localparam fx_t   FX_MIN   = {1'b1, {(DATA_W-1){1'b0}}};

  function automatic fx_t fx_sat(input wide_t v);
    if (v > WIDE_MAX)      return FX_MAX;
    else if (v < WIDE_MIN) return FX_MIN;
    else                   return fx_t'(v[DATA_W-1:0]);
  endfunction

  function automatic fx_t fx_add(input fx_t a, input fx_t b);
    return fx_sat(wide_t'(a) + wide_t'(b));
  endfunction

  function automatic fx_t fx_sub(input fx_t a, input fx_t b);
    return fx_sat(wide_t'(a) - wide_t'(b));
  endfunction

  function automatic fx_t fx_mul(input fx_t a, input fx_t b);
    wide_t p;
    p = wide_t'(a) * wide_t'(b);
    return fx_sat(p >>> FRAC_W);
  endfunction
endpackage

// File: rtl/fdtd_line_buf.sv
module fdtd_line_buf #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [WIDTH-1:0]  rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // read returns the pre-write content in the writing cycle
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/fdtd_e_update.sv
module fdtd_e_update
  import fdtd_pkg::*;
(
  input  fx_t ca_i,
  input  fx_t cb_i,
  input  fx_t ex_i,
  input  fx_t ey_i,
  input  fx_t hz_i,
  input  fx_t hz_left_i,
  input  fx_t hz_up_i,
  output fx_t ex_o,
  output fx_t ey_o
);
  fx_t dx, dy;

  always_comb begin
    dx   = fx_sub(hz_i, hz_left_i);
    dy   = fx_sub(hz_up_i, hz_i);
    ex_o = fx_add(fx_mul(ca_i, ex_i), fx_mul(cb_i, dx));
    ey_o = fx_add(fx_mul(ca_i, ey_i), fx_mul(cb_i, dy));
  end
endmodule

// File: rtl/fdtd_h_update.sv
module fdtd_h_update
  import fdtd_pkg::*;
(
  input  fx_t  da_i,
  input  fx_t  db_i,
  input  fx_t  hz_old_i,
  input  fx_t  ex_here_i,
  input  fx_t  ex_right_i,
  input  fx_t  ey_here_i,
  input  fx_t  ey_below_i,
  input  logic src_hit_i,
  input  fx_t  src_val_i,
  input  fx_t  en_old_i,
  output fx_t  hz_o,
  output fx_t  en_o
);
  fx_t curl, hz_raw;

  always_comb begin
    curl   = fx_add(fx_sub(ex_right_i, ex_here_i), fx_sub(ey_here_i, ey_below_i));
    hz_raw = fx_add(fx_mul(da_i, hz_old_i), fx_mul(db_i, curl));
    hz_o   = src_hit_i ? fx_add(hz_raw, src_val_i) : hz_raw;
    en_o   = fx_add(en_old_i, fx_mul(hz_o, hz_o));
  end
endmodule

// File: rtl/fdtd_stream_stage.sv
module fdtd_stream_stage
  import fdtd_pkg::*;
#(
  parameter int unsigned MAX_W = 64,
  parameter int unsigned MAX_H = 64,
  localparam int unsigned COL_W = (MAX_W > 1) ? $clog2(MAX_W) : 1,
  localparam int unsigned GW_W  = COL_W + 1,
  localparam int unsigned ROW_W = $clog2(MAX_H + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [GW_W-1:0]            grid_w_i,
  input  logic [ROW_W-1:0]           grid_h_i,
  input  logic [ROW_W-1:0]           src_row_i,
  input  logic [COL_W-1:0]           src_col_i,
  input  logic signed [DATA_W-1:0]   src_val_i,
  input  logic [2*DATA_W-1:0]        ca_i,
  input  logic [2*DATA_W-1:0]        cb_i,
  input  logic [2*DATA_W-1:0]        da_i,
  input  logic [2*DATA_W-1:0]        db_i,
  input  logic                       in_valid_i,
  output logic                       in_ready_o,
  input  logic signed [DATA_W-1:0]   in_ex_i,
  input  logic signed [DATA_W-1:0]   in_ey_i,
  input  logic signed [DATA_W-1:0]   in_hz_i,
  input  logic signed [DATA_W-1:0]   in_en_i,
  input  logic                       in_mat_i,
  output logic                       out_valid_o,
  input  logic                       out_ready_i,
  output logic signed [DATA_W-1:0]   out_ex_o,
  output logic signed [DATA_W-1:0]   out_ey_o,
  output logic signed [DATA_W-1:0]   out_hz_o,
  output logic signed [DATA_W-1:0]   out_en_o
);
  localparam int unsigned NBUF = 4;
  localparam int unsigned B_HZ = 0;
  localparam int unsigned B_EN = 1;
  localparam int unsigned B_EX = 2;
  localparam int unsigned B_EY = 3;

  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;
  logic             col_last, in_row, produce, slot_free, step, wr_en, src_hit;
  logic [COL_W-1:0] ahead_addr;
  logic             mat_up;

  logic [NBUF-1:0][DATA_W-1:0] bank_wd, bank_rd;
  logic [NBUF-1:0][COL_W-1:0]  bank_ra;

  fx_t ca_c, cb_c, da_u, db_u;
  fx_t hz_left, hz_up, ex_right, ey_below;
  fx_t ex_new, ey_new, hz_new, en_new;
  fx_t hz_left_q, ex_prev_q;
  fx_t out_ex_q, out_ey_q, out_hz_q, out_en_q;
  logic ov_q;

  // position and stream control
  assign col_last   = (GW_W'(col_q) == grid_w_i - GW_W'(1));
  assign in_row     = (row_q != grid_h_i);
  assign produce    = (row_q != '0);
  assign slot_free  = !ov_q || out_ready_i;
  assign in_ready_o = in_row && (!produce || slot_free);
  assign step       = (in_row ? in_valid_i : 1'b1) && (!produce || slot_free);
  assign wr_en      = step && in_row;
  assign ahead_addr = col_last ? '0 : col_q + COL_W'(1);
  assign src_hit    = produce && ((row_q - ROW_W'(1)) == src_row_i) && (col_q == src_col_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      row_q <= '0;
    end else if (step) begin
      if (col_last) begin
        col_q <= '0;
        row_q <= in_row ? row_q + ROW_W'(1) : '0;
      end else begin
        col_q <= col_q + COL_W'(1);
      end
    end
  end

  // row-delay buffers; ex is read one column ahead
  assign bank_wd[B_HZ] = in_hz_i;
  assign bank_wd[B_EN] = in_en_i;
  assign bank_wd[B_EX] = ex_new;
  assign bank_wd[B_EY] = ey_new;

  for (genvar g = 0; g < NBUF; g++) begin : g_bank
    assign bank_ra[g] = (g == B_EX) ? ahead_addr : col_q;
    fdtd_line_buf #(
      .WIDTH (DATA_W),
      .DEPTH (MAX_W),
      .ADDR_W(COL_W)
    ) u_buf (
      .clk_i  (clk_i),
      .we_i   (wr_en),
      .waddr_i(col_q),
      .wdata_i(bank_wd[g]),
      .raddr_i(bank_ra[g]),
      .rdata_o(bank_rd[g])
    );
  end

  fdtd_line_buf #(
    .WIDTH (1),
    .DEPTH (MAX_W),
    .ADDR_W(COL_W)
  ) u_mat_buf (
    .clk_i  (clk_i),
    .we_i   (wr_en),
    .waddr_i(col_q),
    .wdata_i(in_mat_i),
    .raddr_i(col_q),
    .rdata_o(mat_up)
  );

  // neighbour registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hz_left_q <= '0;
      ex_prev_q <= '0;
    end else if (step) begin
      hz_left_q <= in_hz_i;
      ex_prev_q <= fx_t'(bank_rd[B_EX]);
    end
  end

  assign hz_left  = (col_q == '0) ? '0 : hz_left_q;
  assign hz_up    = produce ? fx_t'(bank_rd[B_HZ]) : '0;
  assign ex_right = col_last ? '0 : fx_t'(bank_rd[B_EX]);
  assign ey_below = in_row ? ey_new : '0;

  // coefficient selection by material
  assign ca_c = in_mat_i ? fx_t'(ca_i[2*DATA_W-1:DATA_W]) : fx_t'(ca_i[DATA_W-1:0]);
  assign cb_c = in_mat_i ? fx_t'(cb_i[2*DATA_W-1:DATA_W]) : fx_t'(cb_i[DATA_W-1:0]);
  assign da_u = mat_up   ? fx_t'(da_i[2*DATA_W-1:DATA_W]) : fx_t'(da_i[DATA_W-1:0]);
  assign db_u = mat_up   ? fx_t'(db_i[2*DATA_W-1:DATA_W]) : fx_t'(db_i[DATA_W-1:0]);

  fdtd_e_update u_e (
    .ca_i     (ca_c),
    .cb_i     (cb_c),
    .ex_i     (in_ex_i),
    .ey_i     (in_ey_i),
    .hz_i     (in_hz_i),
    .hz_left_i(hz_left),
    .hz_up_i  (hz_up),
    .ex_o     (ex_new),
    .ey_o     (ey_new)
  );

  fdtd_h_update u_h (
    .da_i      (da_u),
    .db_i      (db_u),
    .hz_old_i  (hz_up),
    .ex_here_i (ex_prev_q),
    .ex_right_i(ex_right),
    .ey_here_i (fx_t'(bank_rd[B_EY])),
    .ey_below_i(ey_below),
    .src_hit_i (src_hit),
    .src_val_i (src_val_i),
    .en_old_i  (fx_t'(bank_rd[B_EN])),
    .hz_o      (hz_new),
    .en_o      (en_new)
  );

  // output register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ov_q     <= 1'b0;
      out_ex_q <= '0;
      out_ey_q <= '0;
      out_hz_q <= '0;
      out_en_q <= '0;
    end else if (step && produce) begin
      ov_q     <= 1'b1;
      out_ex_q <= ex_prev_q;
      out_ey_q <= fx_t'(bank_rd[B_EY]);
      out_hz_q <= hz_new;
      out_en_q <= en_new;
    end else if (out_ready_i) begin
      ov_q <= 1'b0;
    end
  end

  assign out_valid_o = ov_q;
  assign out_ex_o    = out_ex_q;
  assign out_ey_o    = out_ey_q;
  assign out_hz_o    = out_hz_q;
  assign out_en_o    = out_en_q;
endmodule

// File: rtl/fdtd_stream_stage_chk.sv
module fdtd_stream_stage_chk
  import fdtd_pkg::*;
#(
  parameter int unsigned ROW_W = 7
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [ROW_W-1:0]         grid_h_i,
  input logic                     in_valid_i,
  input logic                     in_ready_o,
  input logic                     out_valid_o,
  input logic                     out_ready_i,
  input logic signed [DATA_W-1:0] out_ex_o,
  input logic signed [DATA_W-1:0] out_ey_o,
  input logic signed [DATA_W-1:0] out_hz_o,
  input logic signed [DATA_W-1:0] out_en_o,
  input logic [ROW_W-1:0]         row_q
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_idle_R1: assert (!out_valid_o);
    end
  end

  assert_hold_stall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_ex_o) && $stable(out_ey_o)
                                       && $stable(out_hz_o) && $stable(out_en_o)));

  assert_flush_no_take_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_q == grid_h_i) |-> !in_ready_o);

  assert_step_emits_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && (row_q != '0)) |=> out_valid_o);

  assert_full_rate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && out_ready_i && (row_q != grid_h_i)) |-> in_ready_o);
endmodule

bind fdtd_stream_stage fdtd_stream_stage_chk #(.ROW_W(ROW_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .grid_h_i   (grid_h_i),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i),
  .out_ex_o   (out_ex_o),
  .out_ey_o   (out_ey_o),
  .out_hz_o   (out_hz_o),
  .out_en_o   (out_en_o),
  .row_q      (row_q)
);

// File: tb/fdtd_stream_stage_test.sv
module fdtd_stream_stage_test;
  import fdtd_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int unsigned MW  = 16;
  localparam int unsigned MH  = 16;
  localparam int unsigned CW  = $clog2(MW);
  localparam int unsigned GWW = CW + 1;
  localparam int unsigned RWW = $clog2(MH + 1);
  localparam longint LMAX = (longint'(1) <<< (DATA_W - 1)) - 1;
  localparam longint LMIN = -(longint'(1) <<< (DATA_W - 1));

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [GWW-1:0] grid_w_i = GWW'(2);
  logic [RWW-1:0] grid_h_i = RWW'(1);
  logic [RWW-1:0] src_row_i = '1;
  logic [CW-1:0]  src_col_i = '1;
  logic signed [DATA_W-1:0] src_val_i = '0;
  logic [2*DATA_W-1:0] ca_i = '0, cb_i = '0, da_i = '0, db_i = '0;
  logic in_valid_i = 1'b0, out_ready_i = 1'b0, in_mat_i = 1'b0;
  logic signed [DATA_W-1:0] in_ex_i = '0, in_ey_i = '0, in_hz_i = '0, in_en_i = '0;
  logic in_ready_o, out_valid_o;
  logic signed [DATA_W-1:0] out_ex_o, out_ey_o, out_hz_o, out_en_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int c_ex[256], c_ey[256], c_hz[256], c_en[256];
  bit c_mat[256];
  int n_ex[256], n_ey[256], n_hz[256], n_en[256];
  int cav, cbv, dav, dbv, cam, cbm, dam, dbm;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fdtd_stream_stage #(.MAX_W(MW), .MAX_H(MH)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .grid_w_i(grid_w_i), .grid_h_i(grid_h_i),
    .src_row_i(src_row_i), .src_col_i(src_col_i), .src_val_i(src_val_i),
    .ca_i(ca_i), .cb_i(cb_i), .da_i(da_i), .db_i(db_i),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .in_ex_i(in_ex_i), .in_ey_i(in_ey_i), .in_hz_i(in_hz_i), .in_en_i(in_en_i),
    .in_mat_i(in_mat_i), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .out_ex_o(out_ex_o), .out_ey_o(out_ey_o), .out_hz_o(out_hz_o), .out_en_o(out_en_o)
  );

  function automatic int b_sat(input longint v);
    if (v > LMAX) return int'(LMAX);
    if (v < LMIN) return int'(LMIN);
    return int'(v);
  endfunction
  function automatic int b_add(input int a, input int b);
    return b_sat(longint'(a) + longint'(b));
  endfunction
  function automatic int b_sub(input int a, input int b);
    return b_sat(longint'(a) - longint'(b));
  endfunction
  function automatic int b_mul(input int a, input int b);
    longint p;
    p = longint'(a) * longint'(b);
    return b_sat(p >>> FRAC_W);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int rnd_val(input bit big);
    if (big) return int'($urandom);
    return int'($urandom % 32'h0800_0000) - 32'h0400_0000;
  endfunction

  // reference model of one pass, per the requirement equations
  task automatic build_ref(input int w, input int h, input int sr, input int sc, input int sv);
    for (int x = 0; x < h; x++) begin
      for (int y = 0; y < w; y++) begin
        int k, hl, hu, a, b;
        k  = x*w + y;
        hl = (y == 0) ? 0 : c_hz[k-1];
        hu = (x == 0) ? 0 : c_hz[k-w];
        a  = c_mat[k] ? cam : cav;
        b  = c_mat[k] ? cbm : cbv;
        n_ex[k] = b_add(b_mul(a, c_ex[k]), b_mul(b, b_sub(c_hz[k], hl)));
        n_ey[k] = b_add(b_mul(a, c_ey[k]), b_mul(b, b_sub(hu, c_hz[k])));
      end
    end
    for (int x = 0; x < h; x++) begin
      for (int y = 0; y < w; y++) begin
        int k, exr, eyd, curl, hv, a, b;
        k    = x*w + y;
        exr  = (y == w-1) ? 0 : n_ex[k+1];
        eyd  = (x == h-1) ? 0 : n_ey[k+w];
        a    = c_mat[k] ? dam : dav;
        b    = c_mat[k] ? dbm : dbv;
        curl = b_add(b_sub(exr, n_ex[k]), b_sub(n_ey[k], eyd));
        hv   = b_add(b_mul(a, c_hz[k]), b_mul(b, curl));
        if (x == sr && y == sc) hv = b_add(hv, sv);
        n_hz[k] = hv;
        n_en[k] = b_add(c_en[k], b_mul(hv, hv));
      end
    end
  endtask

  task automatic run_pass(input int w, input int h, input bit big, input int pin, input int pout,
                          input int sr, input int sc, input int sv, input int metal_pct,
                          input bit timed);
    int sent, got, cyc, first_in, last_out, stalls, sat_hits;
    bit prev_hold;
    int p_ex, p_ey, p_hz, p_en;
    string tg;
    @(negedge clk_i);
    grid_w_i  = GWW'(w);
    grid_h_i  = RWW'(h);
    src_row_i = RWW'(sr);
    src_col_i = CW'(sc);
    src_val_i = sv;
    ca_i = {cam, cav}; cb_i = {cbm, cbv}; da_i = {dam, dav}; db_i = {dbm, dbv};
    for (int k = 0; k < w*h; k++) begin
      c_ex[k]  = rnd_val(big);
      c_ey[k]  = rnd_val(big);
      c_hz[k]  = rnd_val(big);
      c_en[k]  = big ? rnd_val(1'b1) : int'($urandom % 32'h0100_0000);
      c_mat[k] = (int'($urandom % 100) < metal_pct);
    end
    build_ref(w, h, sr, sc, sv);
    sent = 0; got = 0; cyc = 0; first_in = -1; last_out = -1; stalls = 0;
    sat_hits = 0; prev_hold = 0; p_ex = 0; p_ey = 0; p_hz = 0; p_en = 0;
    while (got < w*h && cyc < 20000) begin
      if (cyc != 0) @(negedge clk_i);
      if (sent < w*h && int'($urandom % 100) < pin) begin
        in_valid_i = 1'b1;
        in_ex_i = c_ex[sent]; in_ey_i = c_ey[sent]; in_hz_i = c_hz[sent];
        in_en_i = c_en[sent]; in_mat_i = c_mat[sent];
      end else begin
        in_valid_i = 1'b0;
        in_ex_i = rnd_val(1'b1); in_mat_i = $urandom % 2;
      end
      out_ready_i = (int'($urandom % 100) < pout);
      #(CLK_PERIOD/2 - 1);
      if (prev_hold) begin
        chk(out_valid_o && out_ex_o == p_ex && out_ey_o == p_ey && out_hz_o == p_hz
            && out_en_o == p_en, "R9", "stalled output held (hz)", out_hz_o, p_hz);
      end
      if (sent == w*h && (w*h - got) >= 2)
        chk(!in_ready_o, "R8", "in_ready during flush", in_ready_o, 0);
      if (timed && in_valid_i && !in_ready_o) stalls++;
      if (out_valid_o && out_ready_i) begin
        int r, cc;
        r  = got / w;
        cc = got % w;
        tg = big ? "R7" : "R2";
        chk(out_ex_o == n_ex[got], tg, $sformatf("ex cell %0d", got), out_ex_o, n_ex[got]);
        chk(out_ey_o == n_ey[got], tg, $sformatf("ey cell %0d", got), out_ey_o, n_ey[got]);
        if (!big) tg = (r == sr && cc == sc) ? "R5" : (c_mat[got] ? "R4" : "R3");
        chk(out_hz_o == n_hz[got], tg, $sformatf("hz cell %0d", got), out_hz_o, n_hz[got]);
        if (!big) tg = "R6";
        chk(out_en_o == n_en[got], tg, $sformatf("energy cell %0d", got), out_en_o, n_en[got]);
        if (metal_pct == 100 && cam == 0 && cbm == 0)
          chk(out_ex_o == 0 && out_ey_o == 0, "R4", "metal zeroes E", out_ex_o, 0);
        if (out_hz_o == int'(LMAX) || out_hz_o == int'(LMIN) ||
            out_ex_o == int'(LMAX) || out_ex_o == int'(LMIN)) sat_hits++;
        last_out = cyc;
        got++;
      end
      prev_hold = out_valid_o && !out_ready_i;
      p_ex = out_ex_o; p_ey = out_ey_o; p_hz = out_hz_o; p_en = out_en_o;
      if (in_valid_i && in_ready_o) begin
        if (first_in < 0) first_in = cyc;
        sent++;
      end
      @(posedge clk_i);
      cyc++;
    end
    chk(cyc < 20000, "R8", "pass finished before watchdog", cyc, 20000);
    @(negedge clk_i);
    in_valid_i  = 1'b0;
    out_ready_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      #(CLK_PERIOD/2 - 1);
      chk(!out_valid_o, "R8", "no extra output after pass", out_valid_o, 0);
      @(negedge clk_i);
    end
    if (big) chk(sat_hits > 0, "R7", "saturated outputs seen", sat_hits, 1);
    if (timed) begin
      chk(last_out - first_in == w*(h+1), "R10", "first-in to last-out clocks",
          last_out - first_in, w*(h+1));
      chk(stalls == 0, "R10", "input stalls at full rate", stalls, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    cav = 32'h0100_0000; cbv = 32'h0080_0000; dav = 32'h0100_0000; dbv = 32'h0080_0000;
    cam = 0;             cbm = 0;             dam = 32'h00C0_0000; dbm = 32'h0040_0000;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #(CLK_PERIOD/2 - 1);
    chk(!out_valid_o, "R1", "out_valid after reset", out_valid_o, 0);
    chk(in_ready_o, "R1", "in_ready after reset", in_ready_o, 1);

    run_pass(5, 4, 1'b0, 70, 60, 2, 3, 32'h0300_0000, 30, 1'b0);
    run_pass(2, 1, 1'b0, 80, 80, 0, 1, -32'h0200_0000, 50, 1'b0);
    run_pass(8, 6, 1'b0, 100, 100, 15, 15, 0, 20, 1'b1);
    run_pass(7, 5, 1'b0, 60, 40, 0, 0, 32'h0100_0000, 100, 1'b0);
    cav = 32'h2000_0000; cbv = 32'h1000_0000; dav = 32'h2000_0000; dbv = 32'h1800_0000;
    run_pass(4, 3, 1'b1, 75, 50, 1, 2, 32'h7000_0000, 0, 1'b0);
    cav = 32'h00F0_0000; cbv = 32'h0040_0000; dav = 32'h00F8_0000; dbv = 32'h0060_0000;
    run_pass(6, 6, 1'b0, 50, 90, 5, 5, -32'h0080_0000, 40, 1'b0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule